// File: doc/BRIEF.md
# Late-Binding Physical Register Allocator

This block hands out physical registers in an out-of-order core only once an instruction has produced its result. At rename a destination receives just a virtual tag, which is the slot it occupies in a small circular in-flight window. No storage is spent at that point. When the instruction finishes, the completion port asks for a physical register for its tag. The block answers in the same cycle with either a grant, which names the register and records the binding, or a retry. A retry means the instruction has to stay in its issue queue and execute again later. A lookup port translates a virtual tag into its bound register, and a commit port retires the oldest instruction.

A static mode input picks one of two ways to keep the machine from deadlocking. In reserving mode, one free register is kept back so that the oldest unfinished instruction can always complete. In stealing mode nothing is kept back. A requester that finds no free register instead takes the register of the youngest finished instruction that is younger than itself. The victim's tag is then broadcast on a revoke output so that consumers waiting on it drop their ready state. At commit, the register that previously held the committed value of the same logical register goes back to the pool.

Top module: `lba_alloc`

## Requirements
- R1: Rename is accepted while fewer than 16 instructions are in flight. `ren_vtag` gives the tag of the next slot, which starts at 0 after reset, counts up by one per accepted rename and wraps from 15 to 0. A newly renamed tag holds no register (a lookup misses), and a rename offered while the window is full changes nothing.
- R2: A completion request for a live tag that has no binding is granted the lowest-numbered free register whenever the active mode allows it. The answer arrives in the same cycle, and from the next cycle on a lookup of that tag returns that register. `cmp_grant` and `cmp_retry` are never high together.
- R3: In reserving mode, a request from any tag other than the oldest live one is granted from the pool only when at least two registers are free. Otherwise it gets a retry. A request from the oldest live tag is granted whenever one register is free.
- R4: In reserving mode, whenever the oldest live instruction holds no register, at least one register is free.
- R5: In stealing mode with an empty pool, the request takes the register of the youngest bound instruction that is younger than the requester. That victim loses its binding (its lookup misses), and in the same cycle `rvk_valid` is high with `rvk_vtag` naming the victim.
- R6: In stealing mode with an empty pool and no bound instruction younger than the requester, the answer is a retry with no revoke.
- R7: A commit request retires the oldest instruction only when it holds a register. `cmt_done` is then high, and the register that until then held the committed value of the same logical destination returns to the pool. If the oldest instruction holds no register, `cmt_done` stays low and nothing changes.
- R8: A register released by a commit can be granted to a completion request in the same cycle.
- R9: A completion request for a tag that is already bound is granted its existing register again and uses no pool entry. A request for a tag that is not live gets neither a grant nor a retry.
- R10: No physical register is bound to two live virtual tags at the same time.
- R11: After reset the window is empty, logical register i is held by physical register i, and physical registers 8 to 15 are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| steal_mode | input | 1 | Static mode select: 0 reserves for the oldest, 1 steals from the youngest |
| ren_valid | input | 1 | Rename request |
| ren_lreg | input | 3 | Logical destination of the renamed instruction |
| ren_ready | output | 1 | Window has a free slot |
| ren_vtag | output | 4 | Virtual tag given to the rename |
| cmp_valid | input | 1 | Completion request |
| cmp_vtag | input | 4 | Tag of the completing instruction |
| cmp_grant | output | 1 | Register granted |
| cmp_retry | output | 1 | No register; instruction must re-execute |
| cmp_preg | output | 4 | Granted physical register |
| cmt_valid | input | 1 | Request to retire the oldest instruction |
| cmt_done | output | 1 | Oldest instruction retired this cycle |
| lkp_vtag | input | 4 | Tag to translate |
| lkp_hit | output | 1 | Tag is live and bound |
| lkp_preg | output | 4 | Bound physical register (0 on a miss) |
| rvk_valid | output | 1 | A binding was stolen this cycle |
| rvk_vtag | output | 4 | Tag of the instruction that lost its register |

## Verification
The assertions assume that `steal_mode` only changes while reset is held. They also assume that the core sends completion requests only for tags it got from rename, at most one per cycle. The bench changes the mode only inside a reset sequence and drives at most one completion and one commit per cycle. Every completion tag it sends comes from the rename sequence it has itself issued, apart from one deliberately dead tag, which covers the case of a request for a tag that is not live.

// File: rtl/lba_pkg.sv
package lba_pkg;

    // Default geometry of the allocator
    localparam int WIN_DEF   = 16;  // in-flight window slots
    localparam int NLOG_DEF  = 8;   // logical registers
    localparam int NPHYS_DEF = 8;   // physical registers beyond committed state

    // Outcome of one completion request
    typedef enum logic [2:0] {
        RSP_NONE,    // no request or tag not live
        RSP_HELD,    // already bound, same register returned
        RSP_FREE,    // taken from the free pool
        RSP_STEAL,   // taken from a younger finished instruction
        RSP_RETRY    // nothing available, re-execute later
    } rsp_e;

    // Distance of a window slot from the head (0 = oldest)
    function automatic int unsigned lba_age(int unsigned idx, int unsigned head,
                                            int unsigned win);
        return (idx + win - head) % win;
    endfunction

endpackage

// File: rtl/lba_free_pool.sv
module lba_free_pool #(
    parameter  int NLOG  = lba_pkg::NLOG_DEF,
    parameter  int NPHYS = lba_pkg::NPHYS_DEF,
    localparam int PREGS = NLOG + NPHYS,
    localparam int PW    = $clog2(PREGS),
    localparam int CW    = $clog2(PREGS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rel_valid,
    input  logic [PW-1:0] rel_id,
    input  logic          take_valid,
    input  logic [PW-1:0] take_id,
    output logic          pick_valid,
    output logic [PW-1:0] pick_id,
    output logic [CW-1:0] avail_cnt,
    output logic [CW-1:0] free_cnt
);

    logic [PREGS-1:0] free_q;
    logic [PREGS-1:0] rel_mask;
    logic [PREGS-1:0] take_mask;
    logic [PREGS-1:0] eff_free;

    assign rel_mask  = rel_valid  ? (PREGS'(1) << rel_id)  : '0;
    assign take_mask = take_valid ? (PREGS'(1) << take_id) : '0;
    // a release in this cycle is visible to this cycle's allocation
    assign eff_free  = free_q | rel_mask;

    always_comb begin
        pick_id = '0;
        for (int i = PREGS - 1; i >= 0; i--) begin
            if (eff_free[i]) pick_id = PW'(i);
        end
        pick_valid = |eff_free;
    end

    always_comb begin
        avail_cnt = '0;
        free_cnt  = '0;
        for (int i = 0; i < PREGS; i++) begin
            avail_cnt = avail_cnt + CW'(eff_free[i]);
            free_cnt  = free_cnt + CW'(free_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PREGS; i++) free_q[i] <= (i >= NLOG);
        end else begin
            free_q <= eff_free & ~take_mask;
        end
    end

    // R2: an allocation only ever takes a register that is free this cycle
    p_take_free_r2: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> eff_free[take_id]);

    // R7: a register coming back from commit was not already in the pool
    p_no_double_free_r7: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> !free_q[rel_id]);

endmodule

// File: rtl/lba_victim_pick.sv
module lba_victim_pick #(
    parameter  int WIN = lba_pkg::WIN_DEF,
    localparam int VW  = $clog2(WIN)
) (
    input  logic [WIN-1:0] held_vec,
    input  logic [VW-1:0]  head,
    input  logic [VW-1:0]  req_idx,
    output logic           found,
    output logic [VW-1:0]  victim
);
    import lba_pkg::*;

    int unsigned req_age;
    int unsigned best_age;
    int unsigned cand_age;

    always_comb begin
        req_age  = lba_age(int'(req_idx), int'(head), WIN);
        found    = 1'b0;
        victim   = '0;
        best_age = 0;
        cand_age = 0;
        for (int i = 0; i < WIN; i++) begin
            cand_age = lba_age(i, int'(head), WIN);
            if (held_vec[i] && cand_age > req_age && (!found || cand_age > best_age)) begin
                found    = 1'b1;
                best_age = cand_age;
                victim   = VW'(i);
            end
        end
    end

endmodule

// File: rtl/lba_window.sv
module lba_window #(
    parameter  int WIN   = lba_pkg::WIN_DEF,
    parameter  int NLOG  = lba_pkg::NLOG_DEF,
    parameter  int NPHYS = lba_pkg::NPHYS_DEF,
    localparam int VW    = $clog2(WIN),
    localparam int PW    = $clog2(NLOG + NPHYS),
    localparam int LW    = $clog2(NLOG)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ren_fire,
    input  logic [LW-1:0]           ren_lreg,
    input  logic                    bind_valid,
    input  logic [VW-1:0]           bind_idx,
    input  logic [PW-1:0]           bind_preg,
    input  logic                    unbind_valid,
    input  logic [VW-1:0]           unbind_idx,
    input  logic                    cmt_fire,
    output logic [VW-1:0]           head,
    output logic [VW-1:0]           tail,
    output logic [VW:0]             cnt,
    output logic [WIN-1:0]          live_vec,
    output logic [WIN-1:0]          bound_vec,
    output logic [WIN-1:0][PW-1:0]  preg_arr,
    output logic [WIN-1:0][LW-1:0]  lreg_arr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            head      <= '0;
            tail      <= '0;
            cnt       <= '0;
            live_vec  <= '0;
            bound_vec <= '0;
            preg_arr  <= '0;
            lreg_arr  <= '0;
        end else begin
            if (ren_fire) begin
                live_vec[tail]  <= 1'b1;
                bound_vec[tail] <= 1'b0;
                lreg_arr[tail]  <= ren_lreg;
                tail            <= tail + 1'b1;
            end
            if (bind_valid) begin
                bound_vec[bind_idx] <= 1'b1;
                preg_arr[bind_idx]  <= bind_preg;
            end
            if (unbind_valid) begin
                bound_vec[unbind_idx] <= 1'b0;
            end
            if (cmt_fire) begin
                live_vec[head]  <= 1'b0;
                bound_vec[head] <= 1'b0;
                head            <= head + 1'b1;
            end
            cnt <= cnt + (VW+1)'(ren_fire) - (VW+1)'(cmt_fire);
        end
    end

    // pairwise search for a register shared by two live bindings
    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            for (int j = i + 1; j < WIN; j++) begin
                if (live_vec[i] && bound_vec[i] && live_vec[j] && bound_vec[j] &&
                    preg_arr[i] == preg_arr[j])
                    dup = 1'b1;
            end
        end
    end

    // R1: occupancy never passes the window size
    p_cnt_cap_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= (VW+1)'(WIN));

    // R2: a new binding lands on a live slot that holds nothing yet
    p_bind_fresh_r2: assert property (@(posedge clk) disable iff (rst)
        bind_valid |-> (live_vec[bind_idx] && !bound_vec[bind_idx]));

    // R5: only a slot that holds a register can be robbed
    p_unbind_held_r5: assert property (@(posedge clk) disable iff (rst)
        unbind_valid |-> bound_vec[unbind_idx]);

    // R7: retiring moves the head by exactly one slot
    p_head_step_r7: assert property (@(posedge clk) disable iff (rst)
        cmt_fire |=> head == $past(head) + 1'b1);

    // R10: bindings of live tags are pairwise distinct
    p_unique_r10: assert property (@(posedge clk) disable iff (rst) !dup);

endmodule

// File: rtl/lba_alloc.sv
module lba_alloc #(
    parameter  int WIN   = lba_pkg::WIN_DEF,
    parameter  int NLOG  = lba_pkg::NLOG_DEF,
    parameter  int NPHYS = lba_pkg::NPHYS_DEF,
    localparam int VW    = $clog2(WIN),
    localparam int PREGS = NLOG + NPHYS,
    localparam int PW    = $clog2(PREGS),
    localparam int LW    = $clog2(NLOG),
    localparam int CW    = $clog2(PREGS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          steal_mode,
    input  logic          ren_valid,
    input  logic [LW-1:0] ren_lreg,
    output logic          ren_ready,
    output logic [VW-1:0] ren_vtag,
    input  logic          cmp_valid,
    input  logic [VW-1:0] cmp_vtag,
    output logic          cmp_grant,
    output logic          cmp_retry,
    output logic [PW-1:0] cmp_preg,
    input  logic          cmt_valid,
    output logic          cmt_done,
    input  logic [VW-1:0] lkp_vtag,
    output logic          lkp_hit,
    output logic [PW-1:0] lkp_preg,
    output logic          rvk_valid,
    output logic [VW-1:0] rvk_vtag
);
    import lba_pkg::*;

    // window state
    logic [VW-1:0]          head, tail;
    logic [VW:0]            cnt;
    logic [WIN-1:0]         live_vec, bound_vec;
    logic [WIN-1:0][PW-1:0] preg_arr;
    logic [WIN-1:0][LW-1:0] lreg_arr;

    // pool interface
    logic          pick_valid;
    logic [PW-1:0] pick_id;
    logic [CW-1:0] avail_cnt, free_cnt;
    logic          rel_valid;
    logic [PW-1:0] rel_id;

    // victim search
    logic          vic_found;
    logic [VW-1:0] vic_idx;

    // committed mapping: logical register -> physical register
    logic [NLOG-1:0][PW-1:0] arch_map;

    logic          ren_fire, cmt_fire;
    logic [VW-1:0] eff_head;
    logic          is_oldest, room_ok;
    rsp_e          rsp;

    assign ren_ready = cnt < (VW+1)'(WIN);
    assign ren_fire  = ren_valid && ren_ready;
    assign ren_vtag  = tail;

    assign cmt_fire  = cmt_valid && live_vec[head] && bound_vec[head];
    assign cmt_done  = cmt_fire;
    assign rel_valid = cmt_fire;
    assign rel_id    = arch_map[lreg_arr[head]];

    // the oldest instruction as seen after this cycle's commit
    assign eff_head  = cmt_fire ? head + 1'b1 : head;
    assign is_oldest = (cmp_vtag == eff_head);

    always_comb begin
        if (steal_mode || is_oldest) room_ok = pick_valid;
        else                         room_ok = avail_cnt >= CW'(2);
    end

    always_comb begin
        rsp = RSP_NONE;
        if (cmp_valid && live_vec[cmp_vtag]) begin
            if (bound_vec[cmp_vtag])        rsp = RSP_HELD;
            else if (room_ok)               rsp = RSP_FREE;
            else if (steal_mode && vic_found) rsp = RSP_STEAL;
            else                            rsp = RSP_RETRY;
        end
    end

    always_comb begin
        case (rsp)
            RSP_HELD:  cmp_preg = preg_arr[cmp_vtag];
            RSP_FREE:  cmp_preg = pick_id;
            RSP_STEAL: cmp_preg = preg_arr[vic_idx];
            default:   cmp_preg = '0;
        endcase
    end

    assign cmp_grant = (rsp == RSP_HELD) || (rsp == RSP_FREE) || (rsp == RSP_STEAL);
    assign cmp_retry = (rsp == RSP_RETRY);
    assign rvk_valid = (rsp == RSP_STEAL);
    assign rvk_vtag  = (rsp == RSP_STEAL) ? vic_idx : '0;

    assign lkp_hit   = live_vec[lkp_vtag] && bound_vec[lkp_vtag];
    assign lkp_preg  = lkp_hit ? preg_arr[lkp_vtag] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLOG; i++) arch_map[i] <= PW'(i);
        end else if (cmt_fire) begin
            arch_map[lreg_arr[head]] <= preg_arr[head];
        end
    end

    lba_window #(.WIN(WIN), .NLOG(NLOG), .NPHYS(NPHYS)) u_window (
        .clk          (clk),
        .rst          (rst),
        .ren_fire     (ren_fire),
        .ren_lreg     (ren_lreg),
        .bind_valid   ((rsp == RSP_FREE) || (rsp == RSP_STEAL)),
        .bind_idx     (cmp_vtag),
        .bind_preg    (cmp_preg),
        .unbind_valid (rsp == RSP_STEAL),
        .unbind_idx   (vic_idx),
        .cmt_fire     (cmt_fire),
        .head         (head),
        .tail         (tail),
        .cnt          (cnt),
        .live_vec     (live_vec),
        .bound_vec    (bound_vec),
        .preg_arr     (preg_arr),
        .lreg_arr     (lreg_arr)
    );

    lba_free_pool #(.NLOG(NLOG), .NPHYS(NPHYS)) u_pool (
        .clk        (clk),
        .rst        (rst),
        .rel_valid  (rel_valid),
        .rel_id     (rel_id),
        .take_valid (rsp == RSP_FREE),
        .take_id    (pick_id),
        .pick_valid (pick_valid),
        .pick_id    (pick_id),
        .avail_cnt  (avail_cnt),
        .free_cnt   (free_cnt)
    );

    lba_victim_pick #(.WIN(WIN)) u_victim (
        .held_vec (live_vec & bound_vec),
        .head     (head),
        .req_idx  (cmp_vtag),
        .found    (vic_found),
        .victim   (vic_idx)
    );

    // R2: one answer per request
    p_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmp_grant && cmp_retry));

    // R3: in reserving mode the oldest live instruction is never refused
    p_oldest_grant_r3: assert property (@(posedge clk) disable iff (rst)
        (!steal_mode && cmp_valid && live_vec[cmp_vtag] && is_oldest) |-> cmp_grant);

    // R3: the mode input is static outside reset
    p_mode_static_r3: assert property (@(posedge clk) disable iff (rst)
        $stable(steal_mode));

    // R4: the kept-back register exists while the oldest is unbound
    p_oldest_free_r4: assert property (@(posedge clk) disable iff (rst)
        (!steal_mode && cnt != '0 && !bound_vec[head]) |-> free_cnt >= CW'(1));

    // R5: a revoked tag is younger than the requester it served
    p_rvk_younger_r5: assert property (@(posedge clk) disable iff (rst)
        rvk_valid |-> lba_age(int'(rvk_vtag), int'(head), WIN) >
                      lba_age(int'(cmp_vtag), int'(head), WIN));

    // R5: stealing happens only when the pool is empty
    p_steal_empty_r5: assert property (@(posedge clk) disable iff (rst)
        rvk_valid |-> (steal_mode && avail_cnt == '0));

endmodule

// File: tb/lba_alloc_tb.sv
module lba_alloc_tb;

    localparam int CLK_PERIOD = 10;

    typedef enum logic [2:0] {OP_RST, OP_REN, OP_CMP, OP_CMT, OP_LKP} op_e;

    typedef struct packed {
        op_e        op;
        logic [3:0] arg;   // lreg, tag or mode
        logic       ea;    // ready / grant / done / hit
        logic       eb;    // retry
        logic [3:0] ev;    // vtag or preg
        logic       er;    // revoke expected
        logic [3:0] ert;   // revoked tag
        logic [3:0] rq;    // requirement number
    } vec_t;

    function automatic vec_t mk(op_e o, int a, int ea, int eb, int ev, int er, int ert, int rq);
        vec_t v;
        v.op = o; v.arg = 4'(a); v.ea = 1'(ea); v.eb = 1'(eb); v.ev = 4'(ev);
        v.er = 1'(er); v.ert = 4'(ert); v.rq = 4'(rq);
        return v;
    endfunction

    localparam int NV = 56;
    localparam vec_t VT [NV] = '{
        // reserving mode
        mk(OP_RST, 0, 0,0, 0,0,0, 11),
        // R1: ten renames, tags in order
        mk(OP_REN, 0, 1,0, 0,0,0, 1), mk(OP_REN, 1, 1,0, 1,0,0, 1),
        mk(OP_REN, 2, 1,0, 2,0,0, 1), mk(OP_REN, 3, 1,0, 3,0,0, 1),
        mk(OP_REN, 4, 1,0, 4,0,0, 1), mk(OP_REN, 5, 1,0, 5,0,0, 1),
        mk(OP_REN, 6, 1,0, 6,0,0, 1), mk(OP_REN, 7, 1,0, 7,0,0, 1),
        mk(OP_REN, 0, 1,0, 8,0,0, 1), mk(OP_REN, 1, 1,0, 9,0,0, 1),
        mk(OP_LKP, 9, 0,0, 0,0,0, 1),           // R1: no register at rename
        // R2 / R11: pool 8..15 handed out lowest first
        mk(OP_CMP, 9, 1,0, 8,0,0, 2),  mk(OP_CMP, 8, 1,0, 9,0,0, 2),
        mk(OP_CMP, 7, 1,0, 10,0,0, 2), mk(OP_CMP, 6, 1,0, 11,0,0, 2),
        mk(OP_CMP, 5, 1,0, 12,0,0, 2), mk(OP_CMP, 4, 1,0, 13,0,0, 2),
        mk(OP_CMP, 3, 1,0, 14,0,0, 3),
        mk(OP_CMP, 2, 0,1, 0,0,0, 3),           // R3: last one kept back
        mk(OP_CMP, 0, 1,0, 15,0,0, 3),          // R3: oldest takes it
        mk(OP_LKP, 0, 1,0, 15,0,0, 2),
        mk(OP_CMP, 0, 1,0, 15,0,0, 9),          // R9: repeat request
        mk(OP_CMT, 0, 1,0, 0,0,0, 7),           // R7: frees preg 0
        mk(OP_CMP, 2, 0,1, 0,0,0, 3),           // R3: 2 is not oldest
        mk(OP_CMP, 1, 1,0, 0,0,0, 3),
        mk(OP_CMT, 0, 1,0, 0,0,0, 7),           // frees preg 1
        mk(OP_CMT, 0, 0,0, 0,0,0, 7),           // R7: head unbound
        mk(OP_CMP, 2, 1,0, 1,0,0, 4),           // R4: reserve served
        mk(OP_CMP, 12, 0,0, 0,0,0, 9),          // R9: dead tag
        mk(OP_LKP, 12, 0,0, 0,0,0, 9),
        // stealing mode
        mk(OP_RST, 1, 0,0, 0,0,0, 11),
        mk(OP_REN, 0, 1,0, 0,0,0, 1), mk(OP_REN, 1, 1,0, 1,0,0, 1),
        mk(OP_REN, 2, 1,0, 2,0,0, 1), mk(OP_REN, 3, 1,0, 3,0,0, 1),
        mk(OP_REN, 4, 1,0, 4,0,0, 1), mk(OP_REN, 5, 1,0, 5,0,0, 1),
        mk(OP_REN, 6, 1,0, 6,0,0, 1), mk(OP_REN, 7, 1,0, 7,0,0, 1),
        mk(OP_REN, 0, 1,0, 8,0,0, 1), mk(OP_REN, 1, 1,0, 9,0,0, 1),
        mk(OP_CMP, 1, 1,0, 8,0,0, 2),  mk(OP_CMP, 2, 1,0, 9,0,0, 2),
        mk(OP_CMP, 3, 1,0, 10,0,0, 2), mk(OP_CMP, 4, 1,0, 11,0,0, 2),
        mk(OP_CMP, 5, 1,0, 12,0,0, 2), mk(OP_CMP, 6, 1,0, 13,0,0, 2),
        mk(OP_CMP, 7, 1,0, 14,0,0, 2), mk(OP_CMP, 8, 1,0, 15,0,0, 2),
        mk(OP_CMP, 9, 0,1, 0,0,0, 6),           // R6: nobody younger
        mk(OP_CMP, 0, 1,0, 15,1,8, 5),          // R5: steals from tag 8
        mk(OP_LKP, 8, 0,0, 0,0,0, 5),           // R5: victim unbound
        mk(OP_CMP, 8, 0,1, 0,0,0, 6),           // R6: 9 holds nothing
        mk(OP_CMT, 0, 1,0, 0,0,0, 7),           // frees preg 0
        mk(OP_CMP, 8, 1,0, 0,0,0, 7)
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       steal_mode = 1'b0;
    logic       ren_valid = 1'b0;
    logic [2:0] ren_lreg = '0;
    logic       ren_ready;
    logic [3:0] ren_vtag;
    logic       cmp_valid = 1'b0;
    logic [3:0] cmp_vtag = '0;
    logic       cmp_grant, cmp_retry;
    logic [3:0] cmp_preg;
    logic       cmt_valid = 1'b0;
    logic       cmt_done;
    logic [3:0] lkp_vtag = '0;
    logic       lkp_hit;
    logic [3:0] lkp_preg;
    logic       rvk_valid;
    logic [3:0] rvk_vtag;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lba_alloc u_dut (
        .clk(clk), .rst(rst), .steal_mode(steal_mode),
        .ren_valid(ren_valid), .ren_lreg(ren_lreg), .ren_ready(ren_ready), .ren_vtag(ren_vtag),
        .cmp_valid(cmp_valid), .cmp_vtag(cmp_vtag), .cmp_grant(cmp_grant),
        .cmp_retry(cmp_retry), .cmp_preg(cmp_preg),
        .cmt_valid(cmt_valid), .cmt_done(cmt_done),
        .lkp_vtag(lkp_vtag), .lkp_hit(lkp_hit), .lkp_preg(lkp_preg),
        .rvk_valid(rvk_valid), .rvk_vtag(rvk_vtag)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        ren_valid = 1'b0;
        cmp_valid = 1'b0;
        cmt_valid = 1'b0;
    endtask

    task automatic do_reset(bit mode);
        @(negedge clk);
        quiet();
        rst = 1'b1;
        steal_mode = mode;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_vec(vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.rq);
        if (v.op == OP_RST) begin
            do_reset(v.arg[0]);
            return;
        end
        @(negedge clk);
        quiet();
        case (v.op)
            OP_REN: begin ren_valid = 1'b1; ren_lreg = v.arg[2:0]; end
            OP_CMP: begin cmp_valid = 1'b1; cmp_vtag = v.arg; end
            OP_CMT: cmt_valid = 1'b1;
            default: lkp_vtag = v.arg;
        endcase
        #1;
        case (v.op)
            OP_REN: begin
                chk(ren_ready == v.ea, tag, ren_ready, v.ea);
                chk(ren_vtag == v.ev, tag, ren_vtag, v.ev);
            end
            OP_CMP: begin
                chk(cmp_grant == v.ea, tag, cmp_grant, v.ea);
                chk(cmp_retry == v.eb, tag, cmp_retry, v.eb);
                if (v.ea) chk(cmp_preg == v.ev, tag, cmp_preg, v.ev);
                chk(rvk_valid == v.er, tag, rvk_valid, v.er);
                if (v.er) chk(rvk_vtag == v.ert, tag, rvk_vtag, v.ert);
            end
            OP_CMT: chk(cmt_done == v.ea, tag, cmt_done, v.ea);
            default: begin
                chk(lkp_hit == v.ea, tag, lkp_hit, v.ea);
                if (v.ea) chk(lkp_preg == v.ev, tag, lkp_preg, v.ev);
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R0 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic       hit_s [16];
        logic [3:0] preg_s [16];
        int         hits;
        bit         uniq;

        // R11: state right after reset
        do_reset(1'b0);
        @(negedge clk);
        cmt_valid = 1'b1;
        cmp_valid = 1'b1;
        cmp_vtag  = 4'd0;
        lkp_vtag  = 4'd0;
        #1;
        chk(ren_ready == 1'b1, "R11 ready", ren_ready, 1);
        chk(ren_vtag == 4'd0, "R11 vtag", ren_vtag, 0);
        chk(lkp_hit == 1'b0, "R11 lookup", lkp_hit, 0);
        chk(cmt_done == 1'b0, "R11 commit on empty", cmt_done, 0);
        chk(!cmp_grant && !cmp_retry, "R11 dead completion", {cmp_grant, cmp_retry}, 0);
        chk(rvk_valid == 1'b0, "R11 revoke", rvk_valid, 0);

        // table walk
        for (int k = 0; k < NV; k++) run_vec(VT[k]);

        // R8: commit release granted to a same-cycle request (pool empty before)
        @(negedge clk);
        quiet();
        cmt_valid = 1'b1;
        cmp_valid = 1'b1;
        cmp_vtag  = 4'd9;
        #1;
        chk(cmt_done == 1'b1, "R8 commit", cmt_done, 1);
        chk(cmp_grant == 1'b1, "R8 grant", cmp_grant, 1);
        chk(cmp_preg == 4'd1, "R8 preg", cmp_preg, 1);
        chk(rvk_valid == 1'b0, "R8 no steal", rvk_valid, 0);

        // R7: retire tags 2..8; tag 8 overwrote lreg 0 and releases preg 15
        for (int k = 2; k <= 8; k++) begin
            @(negedge clk);
            quiet();
            cmt_valid = 1'b1;
            #1;
            chk(cmt_done == 1'b1, "R7 retire", cmt_done, 1);
        end

        // R1: renames wrap past 15
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            quiet();
            ren_valid = 1'b1;
            ren_lreg  = 3'd3;
            #1;
            chk(ren_vtag == 4'((10 + k) % 16), "R1 wrap", ren_vtag, (10 + k) % 16);
        end

        // R7: the seven free registers are 2..7 and the released 15
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            quiet();
            cmp_valid = 1'b1;
            cmp_vtag  = 4'((10 + k) % 16);
            #1;
            chk(cmp_grant == 1'b1, "R7 regrant", cmp_grant, 1);
            chk(cmp_preg == 4'((k < 6) ? 2 + k : 15), "R7 released reg",
                cmp_preg, (k < 6) ? 2 + k : 15);
        end

        // R10: scan every tag through the lookup port
        @(negedge clk);
        quiet();
        hits = 0;
        for (int t = 0; t < 16; t++) begin
            lkp_vtag = 4'(t);
            #1;
            hit_s[t]  = lkp_hit;
            preg_s[t] = lkp_preg;
            if (lkp_hit) hits++;
        end
        uniq = 1'b1;
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++)
                if (hit_s[i] && hit_s[j] && preg_s[i] == preg_s[j]) uniq = 1'b0;
        chk(uniq, "R10 distinct bindings", uniq, 1);
        chk(hits == 8, "R10 live bound count", hits, 8);

        // R1: fill the window, then a rename offered while full is dropped
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            quiet();
            ren_valid = 1'b1;
            ren_lreg  = 3'd4;
            #1;
            chk(ren_ready == 1'b1, "R1 fill", ren_ready, 1);
        end
        @(negedge clk);
        quiet();
        ren_valid = 1'b1;
        ren_lreg  = 3'd0;
        #1;
        chk(ren_ready == 1'b0, "R1 full", ren_ready, 0);
        @(negedge clk);
        quiet();
        lkp_vtag = 4'd9;
        #1;
        chk(ren_vtag == 4'd9, "R1 full rename ignored", ren_vtag, 9);
        chk(ren_ready == 1'b0, "R1 still full", ren_ready, 0);
        chk(lkp_hit == 1'b1 && lkp_preg == 4'd1, "R1 oldest untouched", lkp_preg, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule